// File: doc/BRIEF.md
# Address-Pattern Memory Self-Test Engine

This block tests a word-organised memory on its own, with no processor running code. When started, it walks a byte-address window from a configured upper limit down toward a configured lower limit, two bytes per step. At each word it stores a value built from the low sixteen bits of the word's own byte address. It then reads that word back straight away and compares the returned value with what it stored. Every location therefore holds a different value, so address lines that are stuck or shorted show up as well as data faults.

The engine reaches memory through a single request/acknowledge port with a 16-bit data bus and two byte-lane enables. Each access holds its request until the memory acknowledges it, and the engine waits any number of cycles for that. The first wrong read-back stops the sweep. The engine then keeps the failing byte address, the value it expected and the value it observed, until the next start. In a typical system the window inputs are tied to 0x81FFFE (upper) and 0x020000 (lower).

Top module: `mem_selftest`

## Requirements
- R1: After a synchronous reset, busy, done, pass, fail and mem_req are all 0.
- R2: A start accepted in idle latches top_addr and base_addr. The first access is a write to the latched upper address. Every write is followed by a read of the same address before the next write, and each new write address is 2 less than the previous one.
- R3: Writes drive mem_we=1 and reads drive mem_we=0. Every access drives mem_sel=2'b11, meaning both byte lanes, where bit 1 is data bits 15:8 and bit 0 is data bits 7:0. Write data equals mem_addr[15:0].
- R4: Once mem_req is raised, it stays high with mem_addr and mem_we unchanged until the cycle in which mem_ack is sampled high.
- R5: The sweep covers the addresses from the upper limit down to the lower limit plus 2, which is (top-base)/2 locations. The lower limit itself is never accessed. If no mismatch occurs, pass is set. If top <= base, pass is set with no access at all. pass and fail are never both 1.
- R6: On the first read whose data differs from the address pattern, fail is set and no further access is made. fail_addr gets the address, fail_expected gets the pattern and fail_observed gets exactly the word that read returned. The capture register is zero whenever a read is in flight. These outputs hold their values until the next accepted start.
- R7: start is ignored unless the engine is idle. An accepted start clears pass, fail and the failure record, and raises busy in the next cycle.
- R8: When a test finishes, done is high for exactly one cycle. During that cycle busy is 0 and pass/fail already show the result. The engine is then idle.
- R9: The address width ADDR_W (default 24) spans a whole 8 MB part, which is 4,194,304 words. Sweeps have no word-count cap and work up to the very top of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test (accepted only when idle) |
| top_addr | input | ADDR_W | Upper byte address, first location tested |
| base_addr | input | ADDR_W | Lower byte address, end marker (not tested) |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse on completion |
| pass | output | 1 | Last test completed with no mismatch |
| fail | output | 1 | Last test stopped on a mismatch |
| fail_addr | output | ADDR_W | Byte address of the failing location |
| fail_expected | output | 16 | Pattern written to the failing location |
| fail_observed | output | 16 | Word read back from the failing location |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_sel | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completion |

## Verification
The bench builds the engine with the default ADDR_W of 24. It aims its windows at three places: just below the usual upper limit 0x81FFFE, just above the usual lower limit 0x020000, and at the top of the 24-bit space at 0xFFFFFE, where the address pattern is all ones in its upper bits. Keeping each window to a few dozen or a hundred-odd words puts the ordering, the stop-on-first-fault behaviour and the empty or inverted windows within a short run. A responder with random acknowledge delays of zero to three cycles checks that requests are held for the full wait.

// File: rtl/mst_pkg.sv
package mst_pkg;

    localparam int WORD_W     = 16;
    localparam int LANES      = WORD_W / 8;
    localparam int STEP_BYTES = WORD_W / 8;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_CLEAR,
        ST_READ,
        ST_COMPARE,
        ST_FINISH
    } mst_state_e;

    typedef struct packed {
        word_t expected;
        word_t observed;
    } miss_rec_t;

    function automatic lanes_t lane_enables(input logic active);
        return active ? {LANES{1'b1}} : {LANES{1'b0}};
    endfunction

    function automatic logic words_differ(input word_t a, input word_t b);
        return |(a ^ b);
    endfunction

endpackage

// File: rtl/mst_walker.sv
module mst_walker #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] top_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] cur_o,
    output logic              at_base_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(mst_pkg::STEP_BYTES);

    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            base_q <= '0;
        end else if (load) begin
            cur_q  <= top_i;
            base_q <= base_i;
        end else if (step) begin
            cur_q  <= cur_q - STEP;
        end
    end

    assign cur_o     = cur_q;
    assign at_base_o = (cur_q <= base_q);
endmodule

// File: rtl/mst_capture.sv
module mst_capture
    import mst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  capture,
    input  word_t rdata,
    output word_t cap_o
);
    word_t cap_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cap_q <= '0;
        end else if (capture) begin
            cap_q <= rdata;
        end
    end

    assign cap_o = cap_q;
endmodule

// File: rtl/mst_ctrl.sv
module mst_ctrl
    import mst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       at_base,
    input  logic       mismatch,
    input  logic       mem_ack,
    output logic       load,
    output logic       step,
    output logic       clear,
    output logic       capture,
    output logic       set_pass,
    output logic       set_fail,
    output logic       req,
    output logic       we,
    output logic       busy,
    output logic       done
);
    mst_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        step     = 1'b0;
        clear    = 1'b0;
        capture  = 1'b0;
        set_pass = 1'b0;
        set_fail = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (at_base) begin
                    set_pass = 1'b1;
                    state_d  = ST_FINISH;
                end else begin
                    state_d  = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ack) state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                clear   = 1'b1;
                state_d = ST_READ;
            end
            ST_READ: begin
                if (mem_ack) begin
                    capture = 1'b1;
                    state_d = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                if (mismatch) begin
                    set_fail = 1'b1;
                    state_d  = ST_FINISH;
                end else begin
                    step     = 1'b1;
                    state_d  = ST_CHECK;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign req  = (state_q == ST_WRITE) || (state_q == ST_READ);
    assign we   = (state_q == ST_WRITE);
    assign busy = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign done = (state_q == ST_FINISH);
endmodule

// File: rtl/mem_selftest.sv
module mem_selftest
    import mst_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] top_addr,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [15:0]       fail_expected,
    output logic [15:0]       fail_observed,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_sel,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack
);
    logic              load, step, clear, capture, set_pass, set_fail;
    logic              at_base, mismatch;
    logic [ADDR_W-1:0] cur_addr;
    word_t             cap_word;
    word_t             pat_word;
    miss_rec_t         rec_q;
    logic              pass_q, fail_q;
    logic [ADDR_W-1:0] fail_addr_q;

    mst_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .top_i     (top_addr),
        .base_i    (base_addr),
        .cur_o     (cur_addr),
        .at_base_o (at_base)
    );

    mst_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .capture (capture),
        .rdata   (mem_rdata),
        .cap_o   (cap_word)
    );

    mst_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .at_base  (at_base),
        .mismatch (mismatch),
        .mem_ack  (mem_ack),
        .load     (load),
        .step     (step),
        .clear    (clear),
        .capture  (capture),
        .set_pass (set_pass),
        .set_fail (set_fail),
        .req      (mem_req),
        .we       (mem_we),
        .busy     (busy),
        .done     (done)
    );

    assign pat_word = cur_addr[WORD_W-1:0];
    assign mismatch = words_differ(cap_word, pat_word);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
            rec_q       <= '0;
        end else begin
            if (set_pass) pass_q <= 1'b1;
            if (set_fail) begin
                fail_q         <= 1'b1;
                fail_addr_q    <= cur_addr;
                rec_q.expected <= pat_word;
                rec_q.observed <= cap_word;
            end
        end
    end

    assign pass          = pass_q;
    assign fail          = fail_q;
    assign fail_addr     = fail_addr_q;
    assign fail_expected = rec_q.expected;
    assign fail_observed = rec_q.observed;
    assign mem_addr      = cur_addr;
    assign mem_wdata     = pat_word;
    assign mem_sel       = lane_enables(mem_req);
endmodule

// File: rtl/mem_selftest_chk.sv
module mem_selftest_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_sel,
    input logic [15:0]       mem_wdata,
    input logic [15:0]       cap_word
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
    AST_BOTH_LANES: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_sel == 2'b11)); // R3
    AST_WRITE_PATTERN: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata == mem_addr[15:0])); // R3
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail)); // R5
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R6
    AST_CAPTURE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (cap_word == 16'h0000)); // R6
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(fail_addr) && $stable(fail) && $stable(pass))); // R6
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && start) |=> busy); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
endmodule

bind mem_selftest mem_selftest_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .fail_addr (fail_addr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_sel   (mem_sel),
    .mem_wdata (mem_wdata),
    .cap_word  (cap_word)
);

// File: tb/mem_selftest_test.sv
`timescale 1ns/1ps
module mem_selftest_test;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] top_addr = '0;
    logic [AW-1:0] base_addr = '0;
    logic          busy, done, pass, fail;
    logic [AW-1:0] fail_addr;
    logic [15:0]   fail_expected, fail_observed;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_sel;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #2 clk = ~clk;

    mem_selftest #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start(start), .top_addr(top_addr), .base_addr(base_addr),
        .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
        .fail_expected(fail_expected), .fail_observed(fail_observed),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_sel(mem_sel),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // memory responder state
    bit            fault_en = 1'b0;
    logic [AW-1:0] fault_addr = '0;
    logic [15:0]   fault_xor = '0;
    logic [AW-1:0] exp_addr = '0;
    bit            exp_write = 1'b1;
    int            n_wr = 0;
    int            n_rd = 0;
    int            wait_cnt = 0;
    logic [15:0]   model_mem [logic [AW-1:0]];

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack  = 1'b0;
            wait_cnt = $urandom_range(0, 3);
        end else if (mem_req) begin
            if (wait_cnt > 0) begin
                wait_cnt--;
            end else begin
                check(mem_sel == 2'b11, "R3", "lane enables", mem_sel, 2'b11);
                check(mem_addr == exp_addr, "R2", "access address", mem_addr, exp_addr);
                if (mem_we) begin
                    check(exp_write, "R2", "write where read due", 0, 1);
                    check(mem_wdata == mem_addr[15:0], "R3", "write data", mem_wdata, mem_addr[15:0]);
                    model_mem[mem_addr] = mem_wdata;
                    exp_write = 1'b0;
                    n_wr++;
                end else begin
                    logic [15:0] rd;
                    check(!exp_write, "R2", "read where write due", 1, 0);
                    rd = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0000;
                    if (fault_en && mem_addr == fault_addr) rd = rd ^ fault_xor;
                    mem_rdata = rd;
                    exp_write = 1'b1;
                    exp_addr  = exp_addr - AW'(2);
                    n_rd++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic summary_and_finish();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_sweep(input logic [AW-1:0] t, input logic [AW-1:0] b, input bit fe,
                             input logic [AW-1:0] fa, input logic [15:0] fx, input bit poke);
        bit exp_fail;
        int exp_n;
        int cyc;
        bit held_ok;
        exp_fail = 1'b0;
        if (t <= b) exp_n = 0;
        else if (fe && fx != 0 && fa <= t && fa > b && ((t - fa) % 2 == 0)) begin
            exp_fail = 1'b1;
            exp_n = int'((t - fa) / 2) + 1;
        end else exp_n = int'((t - b) / 2);

        fault_en = fe; fault_addr = fa; fault_xor = fx;
        exp_addr = t; exp_write = 1'b1; n_wr = 0; n_rd = 0;
        model_mem.delete();

        @(negedge clk);
        top_addr = t; base_addr = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", busy, 1);
        check(pass == 1'b0 && fail == 1'b0, "R7", "verdict cleared", {pass, fail}, 0);
        top_addr = ~t; base_addr = ~b;   // latched values must be used

        cyc = 0;
        while (!done && cyc < 20000) begin
            start = (poke && cyc == 10) ? 1'b1 : 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (cyc >= 20000) begin
            check(1'b0, "R8", "done never seen", 0, 1);
            return;
        end
        check(busy == 1'b0, "R8", "busy low with done", busy, 0);
        check(pass == !exp_fail, "R5", "pass", pass, !exp_fail);
        check(fail == exp_fail, "R6", "fail", fail, exp_fail);
        check(n_wr == exp_n, "R5", "write count", n_wr, exp_n);
        check(n_rd == exp_n, "R5", "read count", n_rd, exp_n);
        if (exp_fail) begin
            check(fail_addr == fa, "R6", "fail address", fail_addr, fa);
            check(fail_expected == fa[15:0], "R6", "expected word", fail_expected, fa[15:0]);
            check(fail_observed == (fa[15:0] ^ fx), "R6", "observed word", fail_observed, fa[15:0] ^ fx);
        end else begin
            check(fail_addr == '0, "R6", "fail address cleared", fail_addr, 0);
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle", done, 0);
        held_ok = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (mem_req || fail != exp_fail || pass == exp_fail || (exp_fail && fail_addr != fa))
                held_ok = 1'b0;
        end
        check(held_ok && n_wr == exp_n, "R6", "result held, no access after end", n_wr, exp_n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        summary_and_finish();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && pass == 0 && fail == 0 && mem_req == 0,
              "R1", "reset outputs", {busy, done, pass, fail, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && mem_req == 0, "R1", "idle after reset", {busy, mem_req}, 0);

        // R2 R5: clean window above the usual lower limit
        run_sweep(24'h0200FE, 24'h020000, 1'b0, '0, '0, 1'b0);
        // R7: start pulsed while busy, just below the usual upper limit
        run_sweep(24'h81FFFE, 24'h81FF80, 1'b0, '0, '0, 1'b1);
        // R6: fault at the first location
        run_sweep(24'h81FFFE, 24'h81FF00, 1'b1, 24'h81FFFE, 16'h0001, 1'b0);
        // R6: fault at the last tested location (base + 2)
        run_sweep(24'h020040, 24'h020000, 1'b1, 24'h020002, 16'h8000, 1'b0);
        // R5: empty and inverted windows
        run_sweep(24'h020000, 24'h020000, 1'b0, '0, '0, 1'b0);
        check(n_wr == 0, "R5", "empty window no access", n_wr, 0);
        run_sweep(24'h020000, 24'h020010, 1'b0, '0, '0, 1'b0);
        // R9: very top of the 24-bit space
        run_sweep(24'hFFFFFE, 24'hFFFF80, 1'b0, '0, '0, 1'b0);
        check(pass == 1'b1, "R9", "top of address space", pass, 1);
        run_sweep(24'hFFFFFE, 24'hFFFF00, 1'b1, 24'hFFFFF0, 16'hF000, 1'b0);
        check(fail_addr == 24'hFFFFF0, "R9", "fail address in top range", fail_addr, 24'hFFFFF0);

        // constrained random windows and faults
        for (int i = 0; i < 12; i++) begin
            logic [AW-1:0] b;
            logic [AW-1:0] t;
            logic [AW-1:0] fa;
            logic [15:0]   fx;
            int            len;
            bit            fe;
            b   = AW'($urandom_range(0, 24'hFFFF00)) & ~AW'(1);
            len = $urandom_range(1, 40);
            t   = b + AW'(2 * len);
            fe  = bit'($urandom_range(0, 1));
            fa  = t - AW'(2 * $urandom_range(0, len - 1));
            fx  = 16'($urandom_range(1, 16'hFFFF));
            run_sweep(t, b, fe, fa, fx, (len > 20));
        end

        summary_and_finish();
    end
endmodule